// File: doc/BRIEF.md
# Request-Channel Error Checker for a TileLink-UL Register Port

This block sits between the request (A) channel of a TileLink Uncached Lightweight device port and a simple register file. Every request that is accepted is classified in the same cycle as legal or erroneous. The classification looks at the opcode, size, byte mask and address, and at a parameterised register map that states, for each word-aligned register, whether it is readable, whether it is writable and which byte lanes it implements. Only legal requests produce a one-cycle read or write strobe toward the register file. Every request, legal or not, gets exactly one response on the D channel. That response carries an error flag when the request was rejected.

The checker allows only one transaction in flight. Once it accepts a request it drops its ready until the registered response has been taken by the host. Two kinds of rule are applied. Protocol rules always hold. Device rules apply to mapped registers, plus one more: an unmapped address is rejected only while the device-mode input is high. When device mode is low, an unmapped access completes without error, touches nothing, and reads return zero.

Top module: `tlul_req_guard`

## Requirements
- R1: Only opcode 4 (read), 0 (full write) and 1 (partial write) are legal. Any other opcode value gets an error response.
- R2: A size field of 3 is an error. An address whose low bits are not aligned to 2^size bytes is an error: bit 0 must be zero for size 1, and bits 1:0 must be zero for size 2.
- R3: A mask bit set outside the lane span is an error. The span covers 2^size lanes starting at lane address[1:0]. For example, address 0, size 0, mask 0b0010 is rejected.
- R4: A full-write request whose mask is not exactly equal to its lane span is an error.
- R5: An address whose word index (address[7:2]) is not below the register count is unmapped. With device mode high it gets an error. With device mode low it gets no error, raises no strobe, and a read returns zero.
- R6: A write to a mapped register is an error if address[1:0] is nonzero, or if its mask leaves any of that register's implemented byte lanes clear. The default map implements lanes 0xF for registers 0, 2, 3 and 5, lanes 0x3 for register 1 and lane 0x1 for register 4.
- R7: A write with the instruction-type input high is an error. A read with that input high is legal.
- R8: A write to a register that is not writable is an error, and so is a read from a register that is not readable. By default register 2 is read-only and register 3 is write-only.
- R9: A rejected request never raises the read or write strobe. Its response has the error flag set. A rejected read returns all-ones data and a rejected write returns zero data.
- R10: A legal read raises the read strobe with the word index. It responds with opcode 1 and the full 32-bit register word, whatever its mask. A legal write raises the write strobe with the request data and mask, and responds with opcode 0.
- R11: From the cycle after acceptance until the cycle after the response handshake, ready is low and no new request is accepted. While the response waits for the host's ready, it stays stable.
- R12: After reset, no response is valid and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dev_mode_i | input | 1 | Enables errors on unmapped addresses |
| a_valid_i | input | 1 | Request valid |
| a_ready_o | output | 1 | Request ready (high when no transaction is in flight) |
| a_opcode_i | input | 3 | Request opcode |
| a_size_i | input | 2 | Log2 of the transfer size in bytes |
| a_mask_i | input | 4 | Byte-lane mask |
| a_address_i | input | AW (8) | Byte address |
| a_data_i | input | 32 | Write data |
| a_instr_i | input | 1 | Request flagged as instruction type |
| d_valid_o | output | 1 | Response valid |
| d_ready_i | input | 1 | Response ready from the host |
| d_opcode_o | output | 3 | Response opcode: 1 with data, 0 without |
| d_error_o | output | 1 | Response error flag |
| d_data_o | output | 32 | Response read data |
| reg_we_o | output | 1 | Register write strobe |
| reg_re_o | output | 1 | Register read strobe |
| reg_idx_o | output | AW-2 (6) | Register word index |
| reg_wdata_o | output | 32 | Register write data |
| reg_wmask_o | output | 4 | Register write byte mask |
| reg_rdata_i | input | 32 | Register read data, valid in the strobe cycle |

## Verification
The stimulus table has one row per rule. Each rule is paired with a near-miss request that must pass, which separates the rule under test from any broader rule that might also catch the bad row. Examples of such pairs:
- a narrow read with a partial mask that must succeed, against a lane outside the span;
- a one-byte write to a one-byte register that must succeed, against a half-word write to a full-word register;
- an instruction-type read that must succeed, against an instruction-type write.

Unmapped requests are sent with device mode both high and low, so the two outcomes are distinguished on the error flag and on the read data (all ones versus zero). A directed stall test holds the response for several cycles while a second request waits, and proves that the second request's strobe appears only after the handshake.

// File: rtl/tlul_guard_pkg.sv
package tlul_guard_pkg;

  localparam logic [2:0] OP_PUT_FULL = 3'd0;
  localparam logic [2:0] OP_PUT_PART = 3'd1;
  localparam logic [2:0] OP_GET      = 3'd4;

  localparam logic [2:0] RSP_ACK      = 3'd0;
  localparam logic [2:0] RSP_ACK_DATA = 3'd1;

  typedef struct packed {
    logic bad_opcode;
    logic bad_size;
    logic bad_align;
    logic bad_lanes;
    logic bad_full;
    logic bad_unmapped;
    logic bad_offset;
    logic bad_cover;
    logic bad_instr;
    logic bad_perm;
  } err_flags_t;

  // Byte lanes addressed by a transfer of 2^size bytes starting at lane lo.
  function automatic logic [3:0] lane_span(input logic [1:0] size, input logic [1:0] lo);
    logic [3:0] base;
    case (size)
      2'd0:    base = 4'b0001;
      2'd1:    base = 4'b0011;
      default: base = 4'b1111;
    endcase
    return base << lo;
  endfunction

  // Low address bits that must be zero for the given size.
  function automatic logic misaligned(input logic [1:0] size, input logic [1:0] lo);
    case (size)
      2'd0:    return 1'b0;
      2'd1:    return lo[0];
      default: return |lo;
    endcase
  endfunction

  function automatic logic legal_opcode(input logic [2:0] op);
    return (op == OP_GET) || (op == OP_PUT_FULL) || (op == OP_PUT_PART);
  endfunction

endpackage

// File: rtl/tlul_guard_map.sv
module tlul_guard_map #(
  parameter int unsigned IW       = 6,
  parameter int unsigned NUM_REGS = 6,
  parameter logic [NUM_REGS-1:0]   REG_RD    = 6'b110111,
  parameter logic [NUM_REGS-1:0]   REG_WR    = 6'b111011,
  parameter logic [NUM_REGS*4-1:0] REG_BYTES = 24'hF1FF3F
) (
  input  logic [IW-1:0] idx_i,
  output logic          hit_o,
  output logic          rd_ok_o,
  output logic          wr_ok_o,
  output logic [3:0]    bytes_o
);

  logic [NUM_REGS-1:0] match;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    assign match[g] = (idx_i == IW'(g));
  end

  assign hit_o   = |match;
  assign rd_ok_o = |(match & REG_RD);
  assign wr_ok_o = |(match & REG_WR);

  always_comb begin
    bytes_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (match[i]) bytes_o = bytes_o | REG_BYTES[i*4 +: 4];
    end
  end

endmodule

// File: rtl/tlul_guard_classify.sv
module tlul_guard_classify
  import tlul_guard_pkg::*;
(
  input  logic       [2:0] opcode_i,
  input  logic       [1:0] size_i,
  input  logic       [3:0] mask_i,
  input  logic       [1:0] lo_i,
  input  logic             instr_i,
  input  logic             dev_mode_i,
  input  logic             hit_i,
  input  logic             rd_ok_i,
  input  logic             wr_ok_i,
  input  logic       [3:0] bytes_i,
  output err_flags_t       flags_o,
  output logic             err_o,
  output logic             is_write_o,
  output logic             is_read_o
);

  logic [3:0] span;

  assign span       = lane_span(size_i, lo_i);
  assign is_write_o = (opcode_i == OP_PUT_FULL) || (opcode_i == OP_PUT_PART);
  assign is_read_o  = (opcode_i == OP_GET);

  always_comb begin
    flags_o              = '0;
    flags_o.bad_opcode   = !legal_opcode(opcode_i);
    flags_o.bad_size     = (size_i == 2'd3);
    flags_o.bad_align    = !flags_o.bad_size && misaligned(size_i, lo_i);
    flags_o.bad_lanes    = !flags_o.bad_size && ((mask_i & ~span) != 4'b0);
    flags_o.bad_full     = (opcode_i == OP_PUT_FULL) && !flags_o.bad_size && (mask_i != span);
    flags_o.bad_unmapped = !hit_i && dev_mode_i;
    flags_o.bad_offset   = is_write_o && hit_i && (lo_i != 2'd0);
    flags_o.bad_cover    = is_write_o && hit_i && ((mask_i & bytes_i) != bytes_i);
    flags_o.bad_instr    = is_write_o && instr_i;
    flags_o.bad_perm     = hit_i && ((is_write_o && !wr_ok_i) || (is_read_o && !rd_ok_i));
  end

  assign err_o = |flags_o;

endmodule

// File: rtl/tlul_guard_rsp.sv
module tlul_guard_rsp
  import tlul_guard_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          err_i,
  input  logic          is_read_i,
  input  logic          deliver_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          d_ready_i,
  output logic          a_ready_o,
  output logic          d_valid_o,
  output logic [2:0]    d_opcode_o,
  output logic          d_error_o,
  output logic [DW-1:0] d_data_o
);

  logic [DW-1:0] data_nxt;
  logic          rsp_taken;

  assign rsp_taken = d_valid_o && d_ready_i;
  assign a_ready_o = !d_valid_o;

  always_comb begin
    if (err_i && is_read_i) data_nxt = '1;
    else if (deliver_i)     data_nxt = rdata_i;
    else                    data_nxt = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_valid_o  <= 1'b0;
      d_opcode_o <= RSP_ACK;
      d_error_o  <= 1'b0;
      d_data_o   <= '0;
    end else if (accept_i) begin
      d_valid_o  <= 1'b1;
      d_opcode_o <= is_read_i ? RSP_ACK_DATA : RSP_ACK;
      d_error_o  <= err_i;
      d_data_o   <= data_nxt;
    end else if (rsp_taken) begin
      d_valid_o  <= 1'b0;
    end
  end

  // R11
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> d_valid_o && !a_ready_o);

  // R11
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_valid_o && !d_ready_i |=> d_valid_o && $stable(d_data_o) && $stable(d_error_o)
                                && $stable(d_opcode_o));

  // R11
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_taken |=> !d_valid_o && a_ready_o);

  // R9
  err_read_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_valid_o && d_error_o && (d_opcode_o == RSP_ACK_DATA) |-> d_data_o == '1);

endmodule

// File: rtl/tlul_req_guard.sv
module tlul_req_guard
  import tlul_guard_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter int unsigned DW       = 32,
  parameter int unsigned NUM_REGS = 6,
  parameter logic [NUM_REGS-1:0]   REG_RD    = 6'b110111,
  parameter logic [NUM_REGS-1:0]   REG_WR    = 6'b111011,
  parameter logic [NUM_REGS*4-1:0] REG_BYTES = 24'hF1FF3F
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dev_mode_i,
  input  logic          a_valid_i,
  output logic          a_ready_o,
  input  logic [2:0]    a_opcode_i,
  input  logic [1:0]    a_size_i,
  input  logic [3:0]    a_mask_i,
  input  logic [AW-1:0] a_address_i,
  input  logic [DW-1:0] a_data_i,
  input  logic          a_instr_i,
  output logic          d_valid_o,
  input  logic          d_ready_i,
  output logic [2:0]    d_opcode_o,
  output logic          d_error_o,
  output logic [DW-1:0] d_data_o,
  output logic          reg_we_o,
  output logic          reg_re_o,
  output logic [AW-3:0] reg_idx_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic [3:0]    reg_wmask_o,
  input  logic [DW-1:0] reg_rdata_i
);

  localparam int unsigned IW = AW - 2;

  logic       accept;
  logic       hit, rd_ok, wr_ok;
  logic [3:0] bytes;
  err_flags_t flags;
  logic       req_err, is_write, is_read;

  assign accept    = a_valid_i && a_ready_o;
  assign reg_idx_o = a_address_i[AW-1:2];

  tlul_guard_map #(
    .IW(IW), .NUM_REGS(NUM_REGS), .REG_RD(REG_RD), .REG_WR(REG_WR), .REG_BYTES(REG_BYTES)
  ) map_i (
    .idx_i   (reg_idx_o),
    .hit_o   (hit),
    .rd_ok_o (rd_ok),
    .wr_ok_o (wr_ok),
    .bytes_o (bytes)
  );

  tlul_guard_classify classify_i (
    .opcode_i   (a_opcode_i),
    .size_i     (a_size_i),
    .mask_i     (a_mask_i),
    .lo_i       (a_address_i[1:0]),
    .instr_i    (a_instr_i),
    .dev_mode_i (dev_mode_i),
    .hit_i      (hit),
    .rd_ok_i    (rd_ok),
    .wr_ok_i    (wr_ok),
    .bytes_i    (bytes),
    .flags_o    (flags),
    .err_o      (req_err),
    .is_write_o (is_write),
    .is_read_o  (is_read)
  );

  assign reg_we_o    = accept && !req_err && is_write && hit;
  assign reg_re_o    = accept && !req_err && is_read && hit;
  assign reg_wdata_o = a_data_i;
  assign reg_wmask_o = a_mask_i;

  tlul_guard_rsp #(.DW(DW)) rsp_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .err_i      (req_err),
    .is_read_i  (is_read),
    .deliver_i  (reg_re_o),
    .rdata_i    (reg_rdata_i),
    .d_ready_i  (d_ready_i),
    .a_ready_o  (a_ready_o),
    .d_valid_o  (d_valid_o),
    .d_opcode_o (d_opcode_o),
    .d_error_o  (d_error_o),
    .d_data_o   (d_data_o)
  );

  // R9
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_o, reg_re_o}));

  // R9
  write_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> d_valid_o && !d_error_o);

  // R1
  bad_opcode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && (a_opcode_i != OP_GET) && (a_opcode_i != OP_PUT_FULL)
    && (a_opcode_i != OP_PUT_PART) |=> d_error_o);

  // R5
  quiet_unmapped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !dev_mode_i && (reg_idx_o >= IW'(NUM_REGS)) && !reg_we_o && !reg_re_o
    && (a_opcode_i == OP_GET) && (a_size_i == 2'd2) && (a_mask_i == 4'hF)
    && (a_address_i[1:0] == 2'd0) |=> !d_error_o && (d_data_o == '0));

endmodule

// File: tb/tlul_req_guard_tb.sv
module tlul_req_guard_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        dev_mode, a_valid, a_ready, a_instr, d_valid, d_ready, d_error;
  logic        reg_we, reg_re;
  logic [2:0]  a_opcode, d_opcode;
  logic [1:0]  a_size;
  logic [3:0]  a_mask, reg_wmask;
  logic [7:0]  a_address;
  logic [31:0] a_data, d_data, reg_wdata, reg_rdata;
  logic [5:0]  reg_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  assign reg_rdata = 32'h5A5A_0000 | 32'(reg_idx);

  tlul_req_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dev_mode_i(dev_mode),
    .a_valid_i(a_valid), .a_ready_o(a_ready), .a_opcode_i(a_opcode), .a_size_i(a_size),
    .a_mask_i(a_mask), .a_address_i(a_address), .a_data_i(a_data), .a_instr_i(a_instr),
    .d_valid_o(d_valid), .d_ready_i(d_ready), .d_opcode_o(d_opcode), .d_error_o(d_error),
    .d_data_o(d_data), .reg_we_o(reg_we), .reg_re_o(reg_re), .reg_idx_o(reg_idx),
    .reg_wdata_o(reg_wdata), .reg_wmask_o(reg_wmask), .reg_rdata_i(reg_rdata)
  );

  typedef struct packed {
    logic [2:0] op;
    logic [1:0] sz;
    logic [3:0] mask;
    logic [7:0] addr;
    logic       instr;
    logic       dev;
    logic       err;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{3'd4, 2'd2, 4'hF, 8'h00, 1'b0, 1'b1, 1'b0, 4'd10}, // R10 full read
    '{3'd4, 2'd0, 4'h1, 8'h00, 1'b0, 1'b1, 1'b0, 4'd10}, // R10 narrow read, whole word
    '{3'd0, 2'd2, 4'hF, 8'h00, 1'b0, 1'b1, 1'b0, 4'd10}, // R10 full write
    '{3'd2, 2'd2, 4'hF, 8'h00, 1'b0, 1'b1, 1'b1, 4'd1},  // R1 opcode 2
    '{3'd5, 2'd2, 4'hF, 8'h00, 1'b0, 1'b1, 1'b1, 4'd1},  // R1 opcode 5
    '{3'd4, 2'd3, 4'hF, 8'h00, 1'b0, 1'b1, 1'b1, 4'd2},  // R2 size 3
    '{3'd4, 2'd1, 4'h6, 8'h01, 1'b0, 1'b1, 1'b1, 4'd2},  // R2 misaligned half
    '{3'd4, 2'd0, 4'h2, 8'h00, 1'b0, 1'b1, 1'b1, 4'd3},  // R3 lane outside span
    '{3'd1, 2'd2, 4'h3, 8'h04, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 covers 2-byte reg
    '{3'd0, 2'd1, 4'h1, 8'h04, 1'b0, 1'b1, 1'b1, 4'd4},  // R4 full write short mask
    '{3'd4, 2'd2, 4'hF, 8'h40, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 unmapped, dev on
    '{3'd4, 2'd2, 4'hF, 8'h40, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 unmapped read, dev off
    '{3'd0, 2'd2, 4'hF, 8'h40, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 unmapped write, dev off
    '{3'd1, 2'd0, 4'h2, 8'h01, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 write offset
    '{3'd1, 2'd2, 4'h3, 8'h00, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 write misses lanes
    '{3'd1, 2'd0, 4'h1, 8'h10, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 one-byte reg
    '{3'd0, 2'd2, 4'hF, 8'h00, 1'b1, 1'b1, 1'b1, 4'd7},  // R7 instr write
    '{3'd4, 2'd2, 4'hF, 8'h00, 1'b1, 1'b1, 1'b0, 4'd7},  // R7 instr read
    '{3'd0, 2'd2, 4'hF, 8'h08, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 write read-only
    '{3'd4, 2'd2, 4'hF, 8'h0C, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 read write-only
    '{3'd4, 2'd2, 4'hF, 8'h08, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 read read-only
    '{3'd0, 2'd2, 4'hF, 8'h0C, 1'b0, 1'b1, 1'b0, 4'd8}   // R8 write write-only
  };

  task automatic check(input string rq, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    string rq;
    logic mapped, rd, wr, exp_we, exp_re;
    logic [31:0] exp_data;
    rq       = $sformatf("R%0d", v.rq);
    mapped   = (v.addr[7:2] < 6);
    rd       = (v.op == 3'd4);
    wr       = (v.op == 3'd0) || (v.op == 3'd1);
    exp_we   = !v.err && mapped && wr;
    exp_re   = !v.err && mapped && rd;
    exp_data = (v.err && rd) ? 32'hFFFF_FFFF :
               exp_re ? (32'h5A5A_0000 | 32'(v.addr[7:2])) : 32'h0;
    @(negedge clk);
    a_valid = 1; a_opcode = v.op; a_size = v.sz; a_mask = v.mask; a_address = v.addr;
    a_data = {4{v.addr}}; a_instr = v.instr; dev_mode = v.dev;
    #1;
    check(rq, "a_ready", 32'(a_ready), 32'd1);
    check(rq, "reg_we", 32'(reg_we), 32'(exp_we));
    check(rq, "reg_re", 32'(reg_re), 32'(exp_re));
    if (exp_we) begin
      check("R10", "wdata", reg_wdata, {4{v.addr}});
      check("R10", "wmask", 32'(reg_wmask), 32'(v.mask));
    end
    @(negedge clk);
    a_valid = 0;
    check(rq, "d_valid", 32'(d_valid), 32'd1);
    check(rq, "d_error", 32'(d_error), 32'(v.err));
    check(rq, "d_opcode", 32'(d_opcode), rd ? 32'd1 : 32'd0);
    check(rq, "d_data", d_data, exp_data);
    d_ready = 1;
    @(negedge clk);
    d_ready = 0;
    check("R11", "d_valid after take", 32'(d_valid), 32'd0);
    check("R11", "a_ready after take", 32'(a_ready), 32'd1);
  endtask

  initial begin
    a_valid = 0; a_opcode = 0; a_size = 0; a_mask = 0; a_address = 0; a_data = 0;
    a_instr = 0; dev_mode = 1; d_ready = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", "d_valid in reset", 32'(d_valid), 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R12", "d_valid", 32'(d_valid), 32'd0);
    check("R12", "a_ready", 32'(a_ready), 32'd1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R11 stall: second request waits while first response is held
    @(negedge clk);
    a_valid = 1; a_opcode = 3'd4; a_size = 2'd2; a_mask = 4'hF; a_address = 8'h00;
    a_instr = 0; dev_mode = 1;
    @(negedge clk);
    a_address = 8'h04;
    for (int k = 0; k < 3; k++) begin
      check("R11", "a_ready while busy", 32'(a_ready), 32'd0);
      check("R11", "no strobe while busy", 32'(reg_re), 32'd0);
      check("R11", "held data", d_data, 32'h5A5A_0000);
      @(negedge clk);
    end
    d_ready = 1;
    @(negedge clk);
    d_ready = 0;
    check("R11", "second strobe", 32'(reg_re), 32'd1);
    @(negedge clk);
    a_valid = 0;
    check("R11", "second data", d_data, 32'h5A5A_0001);
    d_ready = 1;
    @(negedge clk);
    d_ready = 0;
    check("R11", "idle again", 32'(d_valid), 32'd0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule